// File: doc/BRIEF.md
# Bidirectional Handshake Port Controller

This block turns one 8-bit port into a shared two-way channel between a CPU and a peripheral. Each direction owns a one-byte latch and a full flag. A byte the CPU writes is held in the outbound latch, and the peripheral sees it through an active-low "output full" line. The byte reaches the shared pins only while the peripheral holds its active-low acknowledge. Inbound, the peripheral drives the pins and pulls an active-low strobe. The block latches the byte, raises "input full", and holds the byte until the CPU takes it.

The CPU side is written in stream form. The outbound path is a valid/ready sink: `wr_ready` is high only while the outbound latch is empty, so a write offered while a byte is still waiting stalls with back-pressure until the peripheral acknowledges it. The inbound path is a valid/ready source: `rd_valid` means a latched byte is present, and a beat with `rd_ready` high consumes it. Two interrupt enables, one per direction, are set or cleared through plain control pins. They gate the single interrupt request. A status byte reports the handshake state in fixed bit positions.

Top module: `bidir_hs_port`

## Requirements
- R1: While reset is low, and right after it, the outputs are `obf_n`=1, `ibf`=0, `rd_valid`=0, `wr_ready`=1 and `intr`=0, both interrupt enables are 0, and `status` equals 8'h80.
- R2: A beat with `wr_valid` and `wr_ready` both high stores `wr_data`. From the next cycle `obf_n` is 0 and `wr_ready` is 0.
- R3: While `obf_n` is 0, a clock edge that samples `ack_n` low empties the outbound latch. From the next cycle `obf_n` is 1 and `wr_ready` is 1. The byte seen on `pad_out` during the acknowledge equals the byte that was written.
- R4: `pad_oe` is 1 exactly while `ack_n` is 0 and is 0 otherwise.
- R5: While the outbound latch is full and `ack_n` stays high, `wr_ready` stays 0 and an offered write does not change the held byte.
- R6: While `ibf` is 0, a clock edge that samples `stb_n` low stores `pad_in`. From the next cycle `ibf` and `rd_valid` are 1 and `rd_data` equals the stored byte.
- R7: While `ibf` is 1, a strobe is ignored: `rd_data` keeps the earlier byte.
- R8: A beat with `rd_valid` and `rd_ready` both high clears `ibf` and `rd_valid` from the next cycle.
- R9: A cycle with `en_out_wr` high loads `en_out_val` into the output interrupt enable. A cycle with `en_in_wr` high loads `en_in_val` into the input interrupt enable. Both enables clear on reset.
- R10: `intr` is 1 when the output interrupt enable is 1, `obf_n` is 1 and `ack_n` is 1.
- R11: `intr` is 1 when the input interrupt enable is 1, `ibf` is 1 and `stb_n` is 1. `intr` is 0 when neither this condition nor the R10 condition holds.
- R12: The `status` bits are: bit 7 = `obf_n`, bit 6 = output interrupt enable, bit 5 = `ibf`, bit 4 = input interrupt enable, bit 3 = `intr`, bits 2..0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU offers an outbound byte |
| wr_data | input | 8 | Outbound byte |
| wr_ready | output | 1 | Outbound latch empty, write can be taken |
| rd_valid | output | 1 | Inbound byte available |
| rd_data | output | 8 | Inbound byte |
| rd_ready | input | 1 | CPU consumes the inbound byte |
| en_out_wr | input | 1 | Load the output interrupt enable |
| en_out_val | input | 1 | Value for the output interrupt enable |
| en_in_wr | input | 1 | Load the input interrupt enable |
| en_in_val | input | 1 | Value for the input interrupt enable |
| pad_in | input | 8 | Value read from the shared pins |
| pad_out | output | 8 | Value driven onto the shared pins |
| pad_oe | output | 1 | Pin driver enable |
| obf_n | output | 1 | Active-low outbound byte waiting |
| ack_n | input | 1 | Active-low peripheral acknowledge |
| ibf | output | 1 | Inbound latch full |
| stb_n | input | 1 | Active-low peripheral strobe |
| intr | output | 1 | Combined interrupt request |
| status | output | 8 | Handshake status byte |

## Verification
The assertions assume that `ack_n` and `stb_n` are already synchronous to `clk` and stable around each edge. They also assume that the CPU keeps `wr_data` steady while `wr_valid` waits for `wr_ready`. The stimulus changes every input on the falling edge only, so each rising edge sees settled values. It also holds `wr_valid` with fixed data until the beat is accepted. Strobes and acknowledges are issued only as whole-cycle pulses. The single exception is the deliberate stalled write that probes back-pressure, and it too keeps its data constant.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned ST_OBF_N    = 7;
  localparam int unsigned ST_EN_OUT   = 6;
  localparam int unsigned ST_IBF      = 5;
  localparam int unsigned ST_EN_IN    = 4;
  localparam int unsigned ST_INTR     = 3;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic obf_n, input logic en_out, input logic ibf,
    input logic en_in, input logic intr);
    logic [STAT_W-1:0] s;
    s = '0;
    s[ST_OBF_N]  = obf_n;
    s[ST_EN_OUT] = en_out;
    s[ST_IBF]    = ibf;
    s[ST_EN_IN]  = en_in;
    s[ST_INTR]   = intr;
    return s;
  endfunction
endpackage

// File: rtl/bhp_out_path.sv
module bhp_out_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         ack_n,
  output logic         full,
  output logic [W-1:0] pad_out,
  output logic         pad_oe
);
  logic [W-1:0] hold_q;
  logic         full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (full_q && !ack_n) begin
      full_q <= 1'b0;
    end else if (wr_valid && !full_q) begin
      hold_q <= wr_data;
      full_q <= 1'b1;
    end
  end

  assign full     = full_q;
  assign wr_ready = !full_q;
  assign pad_out  = hold_q;
  assign pad_oe   = !ack_n;

  // R2
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (full_q && hold_q == $past(wr_data)));
  // R3
  ack_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !ack_n) |=> !full_q);
  // R5
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && ack_n) |=> (full_q && $stable(hold_q)));
endmodule

// File: rtl/bhp_in_path.sv
module bhp_in_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_n,
  input  logic [W-1:0] pad_in,
  input  logic         rd_ready,
  output logic         ibf,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] cap_q;
  logic         ibf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      cap_q <= '0;
    end else if (ibf_q && rd_ready) begin
      ibf_q <= 1'b0;
    end else if (!ibf_q && !stb_n) begin
      cap_q <= pad_in;
      ibf_q <= 1'b1;
    end
  end

  assign ibf     = ibf_q;
  assign rd_data = cap_q;

  // R6
  strobe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ibf_q && !stb_n) |=> (ibf_q && cap_q == $past(pad_in)));
  // R7
  strobe_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && !rd_ready) |=> (ibf_q && $stable(cap_q)));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && rd_ready) |=> !ibf_q);
endmodule

// File: rtl/bhp_irq.sv
module bhp_irq
  import bhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_out_wr,
  input  logic              en_out_val,
  input  logic              en_in_wr,
  input  logic              en_in_val,
  input  logic              full,
  input  logic              ack_n,
  input  logic              ibf,
  input  logic              stb_n,
  output logic              intr,
  output logic [STAT_W-1:0] status
);
  logic en_out_q, en_in_q;
  logic out_req, in_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_out_q <= 1'b0;
      en_in_q  <= 1'b0;
    end else begin
      if (en_out_wr) en_out_q <= en_out_val;
      if (en_in_wr)  en_in_q  <= en_in_val;
    end
  end

  always_comb begin
    out_req = en_out_q && !full && ack_n;
    in_req  = en_in_q && ibf && stb_n;
    intr    = out_req || in_req;
    status  = pack_status(!full, en_out_q, ibf, en_in_q, intr);
  end

  // R9
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_out_wr |=> (en_out_q == $past(en_out_val)));
  // R9
  en_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_in_wr |=> (en_in_q == $past(en_in_val)));
  // R11
  intr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_out_q && !en_in_q) |-> !intr);
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
  import bhp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [W-1:0]      wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  input  logic              rd_ready,
  input  logic              en_out_wr,
  input  logic              en_out_val,
  input  logic              en_in_wr,
  input  logic              en_in_val,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic              pad_oe,
  output logic              obf_n,
  input  logic              ack_n,
  output logic              ibf,
  input  logic              stb_n,
  output logic              intr,
  output logic [STAT_W-1:0] status
);
  logic out_full;
  logic in_full;

  bhp_out_path #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .ack_n(ack_n), .full(out_full),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  bhp_in_path #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .pad_in(pad_in),
    .rd_ready(rd_ready), .ibf(in_full), .rd_data(rd_data)
  );

  bhp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en_out_wr(en_out_wr), .en_out_val(en_out_val),
    .en_in_wr(en_in_wr), .en_in_val(en_in_val), .full(out_full),
    .ack_n(ack_n), .ibf(in_full), .stb_n(stb_n), .intr(intr), .status(status)
  );

  assign obf_n    = !out_full;
  assign ibf      = in_full;
  assign rd_valid = in_full;

  // R4
  pad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> !ack_n);
endmodule

// File: tb/bidir_hs_port_tb.sv
`timescale 1ns/1ps
module bidir_hs_port_tb;
  localparam real HALF = 2.5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0, pad_in = '0;
  logic en_out_wr = 1'b0, en_out_val = 1'b0, en_in_wr = 1'b0, en_in_val = 1'b0;
  logic ack_n = 1'b1, stb_n = 1'b1;
  logic wr_ready, rd_valid, pad_oe, obf_n, ibf, intr;
  logic [7:0] rd_data, pad_out, status;

  int checks = 0;
  int errors = 0;
  logic [7:0] out_q[$];
  logic [7:0] in_q[$];

  always #(HALF) clk = ~clk;

  bidir_hs_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .en_out_wr(en_out_wr), .en_out_val(en_out_val),
    .en_in_wr(en_in_wr), .en_in_val(en_in_val), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .obf_n(obf_n), .ack_n(ack_n),
    .ibf(ibf), .stb_n(stb_n), .intr(intr), .status(status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitors: sample before the edge updates state
  always @(posedge clk) begin
    if (rst_n && !ack_n && !obf_n && out_q.size() > 0) begin
      logic [7:0] e;
      e = out_q.pop_front();
      chk(pad_out == e && pad_oe, "R3 handoff byte", pad_out, e);
    end
    if (rst_n && rd_valid && rd_ready && in_q.size() > 0) begin
      logic [7:0] e;
      e = in_q.pop_front();
      chk(rd_data == e, "R6 inbound byte", rd_data, e);
    end
  end

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    do @(posedge clk); while (!wr_ready);
    out_q.push_back(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic cpu_read();
    @(negedge clk);
    rd_ready = 1'b1;
    do @(posedge clk); while (!rd_valid);
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] d, input bit expect_take);
    @(negedge clk);
    pad_in = d; stb_n = 1'b0;
    if (expect_take) in_q.push_back(d);
    @(negedge clk);
    stb_n = 1'b1;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    ack_n = 1'b0;
    @(negedge clk);
    ack_n = 1'b1;
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(obf_n && !ibf && !rd_valid && wr_ready && !intr, "R1 reset outputs",
        {obf_n, ibf, wr_ready, intr}, 4'b1010);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(status == 8'h80, "R1 status after reset", status, 8'h80);
    chk(!pad_oe, "R4 pins released", pad_oe, 0);

    // R2 accept write
    cpu_write(8'hA5); #1;
    chk(!obf_n && !wr_ready, "R2 full after write", {obf_n, wr_ready}, 0);
    chk(status[7] == 1'b0, "R12 status bit7", status, 8'h00);

    // R5 stalled write
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!wr_ready && !obf_n, "R5 back-pressure", wr_ready, 0);
    end
    wr_valid = 1'b0;

    // R3/R4 acknowledge releases byte
    @(negedge clk); ack_n = 1'b0; #1;
    chk(pad_oe && pad_out == 8'hA5, "R4 drive during ack", pad_out, 8'hA5);
    @(negedge clk); ack_n = 1'b1; #1;
    chk(obf_n && wr_ready && !pad_oe, "R3 empty after ack",
        {obf_n, wr_ready, pad_oe}, 3'b110);

    cpu_write(8'h3C);
    ack_pulse();
    cpu_write(8'hC3);
    ack_pulse(); #1;
    chk(out_q.size() == 0, "R3 all bytes handed off", out_q.size(), 0);

    // R6 inbound latch
    strobe(8'h5A, 1'b1); #1;
    chk(ibf && rd_valid && rd_data == 8'h5A, "R6 latch", rd_data, 8'h5A);
    // R7 ignored strobe
    strobe(8'hFF, 1'b0); #1;
    chk(rd_data == 8'h5A && ibf, "R7 strobe ignored", rd_data, 8'h5A);
    cpu_read(); #1;
    chk(!ibf && !rd_valid, "R8 cleared by read", ibf, 0);
    strobe(8'h81, 1'b1);
    cpu_read();
    chk(in_q.size() == 0, "R8 inbound drained", in_q.size(), 0);

    // R9/R10 output interrupt
    @(negedge clk); en_out_wr = 1'b1; en_out_val = 1'b1;
    @(negedge clk); en_out_wr = 1'b0; #1;
    chk(intr && status[6], "R10 intr on empty", status, 8'hC8);
    chk(status == 8'hC8, "R12 status out enable", status, 8'hC8);
    cpu_write(8'h77); #1;
    chk(!intr, "R10 no intr while full", intr, 0);
    @(negedge clk); ack_n = 1'b0; #1;
    chk(!intr, "R10 no intr during ack", intr, 0);
    @(negedge clk); ack_n = 1'b1; #1;
    chk(intr, "R10 intr after ack", intr, 1);
    @(negedge clk); en_out_wr = 1'b1; en_out_val = 1'b0;
    @(negedge clk); en_out_wr = 1'b0; #1;
    chk(!intr && !status[6], "R9 out enable cleared", status, 8'h80);

    // R11 input interrupt
    @(negedge clk); en_in_wr = 1'b1; en_in_val = 1'b1;
    @(negedge clk); en_in_wr = 1'b0; #1;
    chk(!intr && status == 8'h90, "R11 no intr when empty", status, 8'h90);
    @(negedge clk); pad_in = 8'h42; stb_n = 1'b0; in_q.push_back(8'h42);
    @(negedge clk); #1;
    chk(!intr && ibf, "R11 no intr while strobe low", intr, 0);
    stb_n = 1'b1; #1;
    chk(intr, "R11 intr after strobe", intr, 1);
    chk(status == 8'hB8, "R12 status full pattern", status, 8'hB8);
    cpu_read(); #1;
    chk(!intr, "R11 intr drops after read", intr, 0);

    // R9 reset clears enables
    @(negedge clk); en_out_wr = 1'b1; en_out_val = 1'b1;
    @(negedge clk); en_out_wr = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk(status == 8'h80 && !intr, "R9 reset clears enables", status, 8'h80);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule